// File: doc/BRIEF.md
# Compare Flags and Branch Unit

This block holds the outcome of a compare and resolves jumps against it. A compare takes two 32-bit register values, treats them as signed two's-complement numbers, and stores three condition bits: equal, greater and less. The bits stay until the next compare. A jump in a later cycle picks one condition by its opcode and tests it against the stored bits. Greater-or-equal and less-or-equal are formed from the three stored bits at that time.

Every jump target is a base register value plus a 16-bit offset that is sign-extended. A jump through the zero register therefore lands on the offset value itself, which gives an absolute jump. Any other base register gives a register-indirect jump. The taken signal and the target address are combinational and are ready in the same cycle as the jump opcode. The fetch logic outside this block uses them to redirect.

Top module: `cmp_branch_unit`

## Requirements
- R1: Reset is synchronous and active-low, and it clears all three stored flags. After reset, an unconditional jump and a not-equal jump are taken, and the other five conditional jumps are not taken.
- R2: On a clock edge with `op_valid` high and `op_code` = 1 (compare), the unit stores equal = (a == b), greater = (a > b) and less = (a < b). Jumps from the next cycle onward see these values, and exactly one of the three flags is set.
- R3: The greater and less flags compare the operands as signed 32-bit numbers. For example, 0x80000000 is less than 1, and 1 is greater than 0xFFFFFFFF.
- R4: The stored flags do not change in any cycle that is not a valid compare. This includes jumps, the no-op code 0, unused codes, and a compare code presented with `op_valid` low.
- R5: The opcodes select the condition as follows:
  - 8: always taken
  - 9: equal
  - 10: not equal
  - 11: greater
  - 12: greater-or-equal
  - 13: less
  - 14: less-or-equal
- R6: Greater-or-equal is true when the greater or the equal flag is set. Less-or-equal is true when the less or the equal flag is set.
- R7: `jump_target` = `base_val` + the sign extension of `offset` (bit 15 copied upward), taken modulo 2^32.
- R8: With `base_val` = 0, `jump_target` equals the sign-extended offset, which is the absolute jump.
- R9: `jump_taken` and `jump_target` are combinational and reflect the opcode in the same cycle. `jump_taken` is low whenever `op_valid` is low, and for codes 0 to 7 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (compare or jump kind) |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| base_val | input | 32 | Value of the jump's base register |
| offset | input | 16 | Signed jump offset |
| jump_taken | output | 1 | Selected condition holds for a valid jump |
| jump_target | output | 32 | Base plus sign-extended offset |

## Verification
A compare takes effect on one clock edge. For that reason the bench presents a compare, lets exactly one rising edge pass, and only then presents jumps in the following cycles. Taken and target carry no register. They are sampled a quarter period after the inputs change, in the same cycle, before the next rising edge. The hold cases first insert several non-compare cycles and then test the stored flags through a jump.

// File: rtl/bru_pkg.sv
// Package: shared opcode encoding and flag record for the branch unit.
// Assumes 4-bit opcodes; codes not listed are treated as no operation.
package bru_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_CMP = 4'd1,
        OP_JMP = 4'd8,
        OP_JEQ = 4'd9,
        OP_JNE = 4'd10,
        OP_JGT = 4'd11,
        OP_JGE = 4'd12,
        OP_JLT = 4'd13,
        OP_JLE = 4'd14
    } bru_op_e;

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } bru_flags_t;

endpackage

// File: rtl/bru_compare.sv
// Module: signed magnitude compare of two operands into a flag record.
// Assumes operands are two's-complement; purely combinational.
module bru_compare #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    output bru_pkg::bru_flags_t result
);

    // Evaluate equality and signed ordering of the two operands.
    always_comb begin
        result.eq = (opnd_a == opnd_b);
        result.gt = ($signed(opnd_a) > $signed(opnd_b));
        result.lt = ($signed(opnd_a) < $signed(opnd_b));
    end

endmodule

// File: rtl/bru_flag_store.sv
// Module: flag register written only by a valid compare.
// Assumes synchronous active-low reset clears all flags.
module bru_flag_store (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  bru_pkg::bru_flags_t nxt,
    output bru_pkg::bru_flags_t flags
);

    // Capture new flags on compare, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (load)
            flags <= nxt;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (flags == '0)); // R1
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ($countones(flags) == 1)); // R2
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load) |=> $stable(flags)); // R4

endmodule

// File: rtl/bru_cond_sel.sv
// Module: decodes the jump opcode and selects its condition from stored flags.
// Assumes derived conditions are formed here, not stored; clk/rst_n serve checks.
module bru_cond_sel (
    input  logic                clk,
    input  logic                rst_n,
    input  bru_pkg::bru_op_e    op,
    input  bru_pkg::bru_flags_t flags,
    output logic                is_jump,
    output logic                cond_ok
);
    import bru_pkg::*;

    logic ge_c;
    logic le_c;

    // Form the derived ordering conditions.
    always_comb begin
        ge_c = flags.gt | flags.eq;
        le_c = flags.lt | flags.eq;
    end

    // Select the condition named by the opcode.
    always_comb begin
        is_jump = 1'b1;
        cond_ok = 1'b0;
        unique case (op)
            OP_JMP: cond_ok = 1'b1;
            OP_JEQ: cond_ok = flags.eq;
            OP_JNE: cond_ok = ~flags.eq;
            OP_JGT: cond_ok = flags.gt;
            OP_JGE: cond_ok = ge_c;
            OP_JLT: cond_ok = flags.lt;
            OP_JLE: cond_ok = le_c;
            default: is_jump = 1'b0;
        endcase
    end

    AST_GE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JGE && flags.eq) |-> cond_ok); // R6
    AST_LE_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JLE && flags.eq) |-> cond_ok); // R6
    AST_JMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JMP) |-> (is_jump && cond_ok)); // R5

endmodule

// File: rtl/bru_target.sv
// Module: target adder, base plus sign-extended offset, wrapping.
// Assumes OFS_W <= DATA_W; purely combinational.
module bru_target #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] target
);
    localparam int EXT_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] ofs_ext;

    // Sign-extend the offset and add it to the base.
    always_comb begin
        ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
        target  = base_val + ofs_ext;
    end

endmodule

// File: rtl/cmp_branch_unit.sv
// Module: top of the compare-flags and branch resolution unit.
// Assumes one operation per cycle; flags update at the clock edge of a
// valid compare, jump results are combinational in the jump's cycle.
module cmp_branch_unit #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [DATA_W-1:0] base_val,
    input  logic [OFS_W-1:0]  offset,
    output logic              jump_taken,
    output logic [DATA_W-1:0] jump_target
);
    import bru_pkg::*;

    bru_op_e    op;
    bru_flags_t cmp_res;
    bru_flags_t flags;
    logic       cmp_fire;
    logic       is_jump;
    logic       cond_ok;

    // Decode the raw opcode and the compare strobe.
    always_comb begin
        op       = bru_op_e'(op_code);
        cmp_fire = op_valid && (op == OP_CMP);
    end

    bru_compare #(.DATA_W(DATA_W)) u_cmp (
        .opnd_a (cmp_a),
        .opnd_b (cmp_b),
        .result (cmp_res)
    );

    bru_flag_store u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_fire),
        .nxt   (cmp_res),
        .flags (flags)
    );

    bru_cond_sel u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .flags   (flags),
        .is_jump (is_jump),
        .cond_ok (cond_ok)
    );

    bru_target #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_tgt (
        .base_val (base_val),
        .offset   (offset),
        .target   (jump_target)
    );

    // Combine validity, jump decode and selected condition.
    always_comb jump_taken = op_valid && is_jump && cond_ok;

    AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !jump_taken); // R9
    AST_CMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fire |-> !jump_taken); // R9

endmodule

// File: tb/cmp_branch_unit_test.sv
module cmp_branch_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [31:0] base_val = '0;
    logic [15:0] offset = '0;
    logic        jump_taken;
    logic [31:0] jump_target;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .base_val(base_val), .offset(offset),
        .jump_taken(jump_taken), .jump_target(jump_target)
    );

    // Bench-side model of the stored flags.
    logic m_eq = 1'b0, m_gt = 1'b0, m_lt = 1'b0;

    function automatic logic exp_taken(input logic v, input logic [3:0] c);
        logic r;
        case (c)
            4'd8:  r = 1'b1;
            4'd9:  r = m_eq;
            4'd10: r = !m_eq;
            4'd11: r = m_gt;
            4'd12: r = m_gt || m_eq;
            4'd13: r = m_lt;
            4'd14: r = m_lt || m_eq;
            default: r = 1'b0;
        endcase
        return v && r;
    endfunction

    task automatic check1(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one op for one cycle and check taken in the same cycle.
    task automatic try_op(input logic v, input logic [3:0] c, input string req);
        @(negedge clk);
        op_valid = v; op_code = c;
        #(CLK_PERIOD/4);
        check1(req, {31'd0, jump_taken}, {31'd0, exp_taken(v, c)});
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic sweep_jumps(input string req);
        for (int c = 8; c <= 14; c++) try_op(1'b1, 4'(c), req);
    endtask

    task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd1; cmp_a = a; cmp_b = b;
        @(posedge clk);
        m_eq = (a == b);
        m_gt = ($signed(a) > $signed(b));
        m_lt = ($signed(a) < $signed(b));
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic t_reset;
        m_eq = 0; m_gt = 0; m_lt = 0;
        sweep_jumps("R1 reset flags");
    endtask

    task automatic t_compare;
        do_cmp(32'd5, 32'd7);   sweep_jumps("R2 R5 R6 less");
        do_cmp(32'd7, 32'd5);   sweep_jumps("R2 R5 R6 greater");
        do_cmp(32'd9, 32'd9);   sweep_jumps("R2 R5 R6 equal");
    endtask

    task automatic t_signed;
        do_cmp(32'h8000_0000, 32'd1); try_op(1'b1, 4'd13, "R3 min<1");
        try_op(1'b1, 4'd11, "R3 min not gt");
        do_cmp(32'hFFFF_FFFF, 32'd0); try_op(1'b1, 4'd13, "R3 -1<0");
        do_cmp(32'd1, 32'hFFFF_FFFF); try_op(1'b1, 4'd11, "R3 1>-1");
        try_op(1'b1, 4'd14, "R3 1 not le -1");
    endtask

    task automatic t_hold;
        do_cmp(32'd3, 32'd3);
        @(negedge clk);
        cmp_a = 32'd1; cmp_b = 32'd2;
        op_valid = 1'b0; op_code = 4'd1;
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd0;
        @(negedge clk);
        op_code = 4'd5;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
        sweep_jumps("R4 flags held");
    endtask

    task automatic t_idle;
        try_op(1'b0, 4'd8, "R9 jmp invalid");
        try_op(1'b0, 4'd10, "R9 jne invalid");
        try_op(1'b1, 4'd0, "R9 nop");
        try_op(1'b1, 4'd5, "R9 unused code");
        try_op(1'b1, 4'd15, "R9 code 15");
    endtask

    task automatic tgt(input logic [31:0] b, input logic [15:0] o, input string req);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd8; base_val = b; offset = o;
        #(CLK_PERIOD/4);
        check1(req, jump_target, b + {{16{o[15]}}, o});
        check1({req, " taken"}, {31'd0, jump_taken}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic t_target;
        tgt(32'h0000_1000, 16'h0010, "R7 positive offset");
        tgt(32'h0000_1000, 16'hFFFC, "R7 negative offset");
        tgt(32'hFFFF_FFFF, 16'h0001, "R7 wrap");
        tgt(32'h0000_0000, 16'h8000, "R8 absolute negative");
        tgt(32'h0000_0000, 16'h1234, "R8 absolute positive");
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_compare();
        t_signed();
        t_hold();
        t_idle();
        t_target();
        do_cmp(32'd4, 32'd8);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        finish_run();
    end

endmodule